// File: doc/BRIEF.md
# UART Interrupt Identification and Idle Timeout

This block collects the interrupt causes of a 16550-style serial port, picks the most urgent enabled one and reports it as a 4-bit identification code. It drives one active-high interrupt line. It also exposes the two FIFO-mode status bits that software reads alongside the code. The surrounding port logic feeds it level and pulse events: line errors, received-data levels, transmitter-empty state, modem changes and read/write strobes. It owns only the latching, clearing and ranking of these sources.

The block also times the gap after the last received character. A character-time tick from the baud logic advances an idle counter. Once the gap grows past a configured number of character times (four by default), an end-of-receive-data source is raised. This tells a driver that the far end has finished its burst. Ticks that occur while the receiver is held off by hardware handshaking do not count, and a stall restarts the idle measurement. Software clears the source by dropping its enable bit. Setting the enable again does not raise the source again until new data arrives and a fresh idle gap elapses.

Top module: `uart_int_ident`

## Requirements
- R1: `iid_o[3:0]` uses these codes: 0x1 none pending, 0x6 line error, 0x4 received data, 0xC receive timeout, 0x8 end of receive data, 0x2 transmitter empty, 0x0 modem change. Bit 0 is low exactly when a source is pending, and `irq_o` is high exactly then. After reset the code is 0x1 and `irq_o` is low.
- R2: The reported source follows this priority, highest first: line error, received data, receive timeout, end of receive data, transmitter empty, modem change.
- R3: The received-data source follows `rx_avail_i` while `ier_i[0]` is set. The receive-timeout source follows `rx_tmo_i` while `ier_i[4]` is set. Neither source latches.
- R4: A `line_err_i` pulse latches a line-error flag. The flag is reported while `ier_i[2]` is set and is cleared by `lsr_rd_i`.
- R5: The transmitter-empty flag is set when `thr_empty_i && ier_i[1]` rises. It is reported while `ier_i[1]` is set. It is cleared by `thr_wr_i`, or by `iir_rd_i` in a cycle where code 0x2 is the reported code. A read while another code is reported leaves it pending.
- R6: A `msr_chg_i` pulse latches a modem flag. The flag is reported while `ier_i[3]` is set and is cleared by `msr_rd_i`.
- R7: After a `rx_push_i` pulse, with `ier_i[5]` set, code 0x8 appears one cycle after the clock edge that counts the fifth `char_tick_i`. Four ticks leave it absent.
- R8: A cycle with `hs_stall_i` high restarts the idle count from zero. Ticks seen during the stall do not count toward R7.
- R9: Code 0x8 is never reported while `ier_i[5]` is low, and a low enable clears the pending flag. Re-enabling does not raise it again until a new `rx_push_i` is followed by a full idle gap.
- R10: `iid_o[7:6]` read 2'b11 when `fifo_en_i` is high and 2'b00 otherwise. `iid_o[5:4]` always read zero.
- R11: With `ier_i` all zero, `irq_o` stays low whatever the source inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ier_i | input | 6 | Enables: 0 rx data, 1 tx empty, 2 line error, 3 modem, 4 rx timeout, 5 end of receive |
| fifo_en_i | input | 1 | FIFO mode is on |
| rx_avail_i | input | 1 | Received data at or above trigger level |
| rx_tmo_i | input | 1 | Receive FIFO timeout condition |
| rx_push_i | input | 1 | Pulse: one character received |
| line_err_i | input | 1 | Pulse: parity, overrun or framing error |
| lsr_rd_i | input | 1 | Pulse: line status read |
| msr_chg_i | input | 1 | Pulse: modem input changed |
| msr_rd_i | input | 1 | Pulse: modem status read |
| thr_empty_i | input | 1 | Transmit holding register empty |
| thr_wr_i | input | 1 | Pulse: transmit data written |
| iir_rd_i | input | 1 | Pulse: identification register read |
| char_tick_i | input | 1 | Pulse: one character time elapsed |
| hs_stall_i | input | 1 | Receiver held off by hardware handshake |
| iid_o | output | 8 | Identification value: FIFO status in 7:6, code in 3:0 |
| irq_o | output | 1 | Interrupt request |

## Verification
The first sweep covers all 32 combinations of the five non-timer sources with every enable on, and the FIFO mode toggles across the sweep. Each pattern's expected code is computed from the priority order, so any inversion between two adjacent ranks shows up. The second sweep holds every source pending and walks all 32 enable masks, which tells a missing enable gate apart from a priority fault. Directed sequences then cover the clear paths (status reads, a read while another code is shown, transmit writes) and the idle timer. The timer cases check four ticks against five, a stall in the middle of a gap, and a re-enable with no new data.

// File: rtl/uart_iid_pkg.sv
package uart_iid_pkg;
  typedef enum logic [3:0] {
    IID_MODEM  = 4'h0,
    IID_NONE   = 4'h1,
    IID_THRE   = 4'h2,
    IID_RXDATA = 4'h4,
    IID_LINE   = 4'h6,
    IID_EORD   = 4'h8,
    IID_RXTMO  = 4'hC
  } iid_code_e;

  localparam int IER_W     = 6;
  localparam int IER_RX    = 0;
  localparam int IER_TX    = 1;
  localparam int IER_LINE  = 2;
  localparam int IER_MODEM = 3;
  localparam int IER_TMO   = 4;
  localparam int IER_EORD  = 5;
endpackage

// File: rtl/uart_eord_timer.sv
module uart_eord_timer #(
  parameter int IDLE_CHARS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_push_i,
  input  logic char_tick_i,
  input  logic hs_stall_i,
  input  logic en_i,
  output logic pend_o
);
  localparam int LIMIT = IDLE_CHARS + 1;
  localparam int CNT_W = $clog2(LIMIT + 1);

  logic             armed_q, pend_q;
  logic [CNT_W-1:0] cnt_q;
  logic             idle_over;

  assign idle_over = (cnt_q == CNT_W'(LIMIT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (rx_push_i) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end else begin
      if (hs_stall_i)                              cnt_q <= '0;
      else if (char_tick_i && armed_q && !idle_over) cnt_q <= cnt_q + 1'b1;
      // one shot per idle gap
      if (armed_q && idle_over && en_i)            armed_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        pend_q <= 1'b0;
    else if (!en_i)                     pend_q <= 1'b0;
    else if (armed_q && idle_over)      pend_q <= 1'b1;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/uart_src_flags.sv
module uart_src_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_err_i,
  input  logic lsr_rd_i,
  input  logic msr_chg_i,
  input  logic msr_rd_i,
  input  logic thr_empty_i,
  input  logic tx_en_i,
  input  logic thr_wr_i,
  input  logic iir_rd_i,
  input  logic thre_shown_i,
  output logic line_o,
  output logic modem_o,
  output logic thre_o
);
  logic line_q, modem_q, thre_q, te_lvl_q;
  logic te_lvl, te_set, te_clr;

  assign te_lvl = thr_empty_i & tx_en_i;
  assign te_set = te_lvl & ~te_lvl_q;
  assign te_clr = thr_wr_i | (iir_rd_i & thre_shown_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q   <= 1'b0;
      modem_q  <= 1'b0;
      thre_q   <= 1'b0;
      te_lvl_q <= 1'b0;
    end else begin
      te_lvl_q <= te_lvl;
      if (line_err_i)    line_q <= 1'b1;
      else if (lsr_rd_i) line_q <= 1'b0;
      if (msr_chg_i)     modem_q <= 1'b1;
      else if (msr_rd_i) modem_q <= 1'b0;
      if (te_set)        thre_q <= 1'b1;
      else if (te_clr)   thre_q <= 1'b0;
    end
  end

  assign line_o  = line_q;
  assign modem_o = modem_q;
  assign thre_o  = thre_q;
endmodule

// File: rtl/uart_iid_prio.sv
module uart_iid_prio
  import uart_iid_pkg::*;
(
  input  logic      line_i,
  input  logic      rxd_i,
  input  logic      tmo_i,
  input  logic      eord_i,
  input  logic      thre_i,
  input  logic      modem_i,
  output iid_code_e code_o
);
  always_comb begin
    if (line_i)       code_o = IID_LINE;
    else if (rxd_i)   code_o = IID_RXDATA;
    else if (tmo_i)   code_o = IID_RXTMO;
    else if (eord_i)  code_o = IID_EORD;
    else if (thre_i)  code_o = IID_THRE;
    else if (modem_i) code_o = IID_MODEM;
    else              code_o = IID_NONE;
  end
endmodule

// File: rtl/uart_int_ident.sv
module uart_int_ident
  import uart_iid_pkg::*;
#(
  parameter int IDLE_CHARS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IER_W-1:0] ier_i,
  input  logic             fifo_en_i,
  input  logic             rx_avail_i,
  input  logic             rx_tmo_i,
  input  logic             rx_push_i,
  input  logic             line_err_i,
  input  logic             lsr_rd_i,
  input  logic             msr_chg_i,
  input  logic             msr_rd_i,
  input  logic             thr_empty_i,
  input  logic             thr_wr_i,
  input  logic             iir_rd_i,
  input  logic             char_tick_i,
  input  logic             hs_stall_i,
  output logic [7:0]       iid_o,
  output logic             irq_o
);
  iid_code_e code;
  logic line_f, modem_f, thre_f, eord_pend;

  uart_src_flags u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .line_err_i  (line_err_i),
    .lsr_rd_i    (lsr_rd_i),
    .msr_chg_i   (msr_chg_i),
    .msr_rd_i    (msr_rd_i),
    .thr_empty_i (thr_empty_i),
    .tx_en_i     (ier_i[IER_TX]),
    .thr_wr_i    (thr_wr_i),
    .iir_rd_i    (iir_rd_i),
    .thre_shown_i(code == IID_THRE),
    .line_o      (line_f),
    .modem_o     (modem_f),
    .thre_o      (thre_f)
  );

  uart_eord_timer #(.IDLE_CHARS(IDLE_CHARS)) u_eord (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_push_i  (rx_push_i),
    .char_tick_i(char_tick_i),
    .hs_stall_i (hs_stall_i),
    .en_i       (ier_i[IER_EORD]),
    .pend_o     (eord_pend)
  );

  uart_iid_prio u_prio (
    .line_i (line_f     & ier_i[IER_LINE]),
    .rxd_i  (rx_avail_i & ier_i[IER_RX]),
    .tmo_i  (rx_tmo_i   & ier_i[IER_TMO]),
    .eord_i (eord_pend  & ier_i[IER_EORD]),
    .thre_i (thre_f     & ier_i[IER_TX]),
    .modem_i(modem_f    & ier_i[IER_MODEM]),
    .code_o (code)
  );

  assign iid_o = {{2{fifo_en_i}}, 2'b00, code};
  assign irq_o = ~code[0];
endmodule

// File: rtl/uart_int_ident_chk.sv
module uart_int_ident_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [5:0] ier_i,
  input logic       fifo_en_i,
  input logic       line_err_i,
  input logic       hs_stall_i,
  input logic [7:0] iid_o,
  input logic       irq_o,
  input logic       eord_pend_i
);
  AST_MASKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ier_i == 6'd0) |-> !irq_o); // R11

  AST_LINE_ERR_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(line_err_i) && ier_i[2]) |-> (iid_o[3:0] == 4'h6)); // R4

  AST_FIFO_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iid_o[7:4] == (fifo_en_i ? 4'hC : 4'h0)); // R10

  AST_EORD_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ier_i[5] |-> (iid_o[3:0] != 4'h8)); // R9

  AST_STALL_NO_EORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(hs_stall_i, 2) |-> !$rose(eord_pend_i)); // R8
endmodule

bind uart_int_ident uart_int_ident_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ier_i      (ier_i),
  .fifo_en_i  (fifo_en_i),
  .line_err_i (line_err_i),
  .hs_stall_i (hs_stall_i),
  .iid_o      (iid_o),
  .irq_o      (irq_o),
  .eord_pend_i(eord_pend)
);

// File: tb/uart_int_ident_tb.sv
module uart_int_ident_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] ier = '0;
  logic fifo_en = 0, rx_avail = 0, rx_tmo = 0, rx_push = 0, line_err = 0, lsr_rd = 0;
  logic msr_chg = 0, msr_rd = 0, thr_empty = 0, thr_wr = 0, iir_rd = 0, tick = 0, stall = 0;
  logic [7:0] iid;
  logic       irq;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_int_ident u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ier_i(ier), .fifo_en_i(fifo_en),
    .rx_avail_i(rx_avail), .rx_tmo_i(rx_tmo), .rx_push_i(rx_push),
    .line_err_i(line_err), .lsr_rd_i(lsr_rd), .msr_chg_i(msr_chg), .msr_rd_i(msr_rd),
    .thr_empty_i(thr_empty), .thr_wr_i(thr_wr), .iir_rd_i(iir_rd),
    .char_tick_i(tick), .hs_stall_i(stall), .iid_o(iid), .irq_o(irq)
  );

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(string req, logic [3:0] code);
    logic [7:0] e;
    e = {fifo_en, fifo_en, 2'b00, code};
    n_cmp++;
    if (iid !== e || irq !== (code != 4'h1)) begin
      n_bad++;
      $display("FAIL %s: iid=%h irq=%b expected iid=%h irq=%b", req, iid, irq, e, code != 4'h1);
    end
  endtask

  function automatic logic [3:0] expect_code(bit le, bit av, bit tm, bit eo, bit te, bit ms);
    if (le) return 4'h6;
    if (av) return 4'h4;
    if (tm) return 4'hC;
    if (eo) return 4'h8;
    if (te) return 4'h2;
    if (ms) return 4'h0;
    return 4'h1;
  endfunction

  task automatic clear_all();
    lsr_rd = 1; msr_rd = 1; thr_wr = 1; thr_empty = 0;
    step();
    lsr_rd = 0; msr_rd = 0; thr_wr = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1; step(); tick = 0; step();
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    chk("R1 reset", 4'h1);

    // sweep A: all source combinations, all enables on
    ier = 6'h1F;
    for (int m = 0; m < 32; m++) begin
      clear_all();
      fifo_en = ~m[2];
      line_err = m[0]; rx_avail = m[1]; rx_tmo = m[2]; thr_empty = m[3]; msr_chg = m[4];
      step();
      line_err = 0; msr_chg = 0;
      chk("R2 source sweep", expect_code(m[0], m[1], m[2], 0, m[3], m[4]));
    end

    // sweep B: all sources pending, walk enables
    clear_all();
    fifo_en = 1;
    line_err = 1; msr_chg = 1; thr_empty = 1; rx_avail = 1; rx_tmo = 1;
    step();
    line_err = 0; msr_chg = 0;
    for (int v = 0; v < 32; v++) begin
      ier = 6'(v);
      step();
      chk(v == 0 ? "R11 masked" : "R3 enable sweep",
          expect_code(v[2], v[0], v[4], 0, v[1], v[3]));
    end

    // clear paths in priority order
    ier = 6'h1F;
    step();
    chk("R4 line shown", 4'h6);
    lsr_rd = 1; step(); lsr_rd = 0;
    chk("R4 lsr read clears", 4'h4);
    rx_avail = 0; step();
    chk("R3 timeout level", 4'hC);
    rx_tmo = 0; step();
    chk("R3 levels not latched", 4'h2);
    iir_rd = 1; step(); iir_rd = 0;
    chk("R5 iir read clears thre", 4'h0);
    msr_rd = 1; step(); msr_rd = 0;
    chk("R6 msr read clears", 4'h1);

    // thre read while another code shown
    thr_empty = 0; step();
    thr_empty = 1; step();
    chk("R5 empty rise", 4'h2);
    line_err = 1; step(); line_err = 0;
    chk("R4 line over thre", 4'h6);
    iir_rd = 1; step(); iir_rd = 0;
    chk("R5 read while line shown", 4'h6);
    lsr_rd = 1; step(); lsr_rd = 0;
    chk("R5 thre still pending", 4'h2);
    thr_wr = 1; step(); thr_wr = 0;
    chk("R5 write clears", 4'h1);
    msr_chg = 1; step(); msr_chg = 0;
    chk("R6 modem latch", 4'h0);
    msr_rd = 1; step(); msr_rd = 0;

    // idle timer
    thr_empty = 0;
    ier = 6'h20;
    step();
    rx_push = 1; step(); rx_push = 0;
    ticks(4);
    chk("R7 four ticks quiet", 4'h1);
    ticks(1);
    chk("R7 fifth tick fires", 4'h8);
    ier = 6'h00; step();
    chk("R9 disable clears", 4'h1);
    ier = 6'h20; step();
    ticks(6);
    chk("R9 no refire without data", 4'h1);

    rx_push = 1; step(); rx_push = 0;
    ticks(3);
    stall = 1; ticks(3); stall = 0;
    chk("R8 stalled quiet", 4'h1);
    ticks(4);
    chk("R8 count restarted", 4'h1);
    ticks(1);
    chk("R8 fires after full gap", 4'h8);
    rx_avail = 1; ier = 6'h21; step();
    chk("R2 data over eord", 4'h4);
    rx_avail = 0; step();
    chk("R7 eord held", 4'h8);
    fifo_en = 0; step();
    chk("R10 fifo off", 4'h8);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: expected completion, got timeout");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule